// File: doc/BRIEF.md
# Speculative Adder with Exact Fallback

This block adds two unsigned W-bit operands and a carry-in. In the cycle an operation is accepted, a fast path predicts each bit's carry from only the K bit positions below it, treating the carry entering that window as zero. The window for the low K+1 bit positions begins at bit 0, so their carries are exact. A small detector, working in that same cycle, flags every operand pair for which this prediction could be wrong. The exact answer is also started in that cycle: a prefix network builds group generate/propagate terms inside fixed blocks of bits, and these terms are captured in registers.

When the detector stays quiet, the speculative sum is the result and it appears one cycle after acceptance. When the detector fires, the block holds off new work by raising a stall and dropping ready. In the second cycle a sparse block-level carry chain combines the registered group terms with the carry-in to form the exact sum. Callers see a valid/ready request side and a result side with a one-cycle done strobe. The result stays on the outputs until the next done.

Top module: `spec_adder`

## Requirements
- R1: After reset, out_done is 0, stall is 0, in_ready is 1, and out_sum and out_cout are 0.
- R2: An operation is accepted on a rising edge with in_valid and in_ready both high. It completes one cycle after acceptance (out_done 1, stall 0) when no flag window exists. A flag window is a start bit s, with 1 <= s <= W-K, such that bits s..s+K-1 all have a XOR b = 1 and bit s-1 has a OR b = 1.
- R3: If a flag window exists, the block shows stall 1, in_ready 0 and out_done 0 one cycle after acceptance. It shows out_done 1 and stall 0 two cycles after acceptance.
- R4: At every out_done, {out_cout, out_sum} equals in_a + in_b + in_cin of the accepted request, as a W+1 bit sum.
- R5: While stall is 1, in_valid and the operands are ignored. No second operation is accepted from them, and no extra out_done follows.
- R6: out_done is high for exactly one cycle per accepted request. out_sum and out_cout hold their value until the next out_done.
- R7: A propagate run that starts at bit 0 is never flagged by itself. For example, a = 0xFF, b = 0, cin = 1 completes in one cycle with sum 0x100.
- R8: A run of K propagate bits preceded by a killed bit (a = b = 0) completes in one cycle. The same run preceded by a generating bit (a = b = 1) takes the two-cycle path. A run of K-1 bits preceded by a generating bit completes in one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request holds valid operands |
| in_ready | output | 1 | Block can accept a request |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| in_cin | input | 1 | Carry-in |
| out_done | output | 1 | One-cycle strobe: result is valid |
| out_sum | output | W | Sum bits |
| out_cout | output | 1 | Carry-out |
| stall | output | 1 | Exact path is finishing; requests are held off |

## Verification
Suppose the detector misses a window. The speculative carry then goes wrong, and the fault shows as a bad sum at the done strobe one cycle after acceptance. Suppose instead it flags too much. Then a case that should complete fast shows stall one cycle after acceptance, so a latency check catches it. A fault in the registered group terms or in the block carry chain shows only on two-cycle operations, as a wrong sum or carry-out at the second-cycle done. The directed long-chain cases and the biased random operands aim at exactly that point. A broken stall handshake shows within one or two cycles, as a missing, early or duplicated done, or as an operation accepted during the stall.

// File: rtl/spec_adder_pkg.sv
package spec_adder_pkg;
  typedef enum logic [0:0] {
    PH_IDLE  = 1'b0,
    PH_FINAL = 1'b1
  } phase_t;
endpackage

// File: rtl/spec_fast_path.sv
module spec_fast_path #(
  parameter int W = 32,
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         err
);
  // carry into bit i, built only from the K positions below i
  function automatic logic [W:0] window_carries(input logic [W-1:0] x,
                                                input logic [W-1:0] y,
                                                input logic c0);
    logic [W:0] c;
    logic cc;
    c = '0;
    c[0] = c0;
    for (int i = 1; i <= W; i++) begin
      cc = (i <= K) ? c0 : 1'b0;
      for (int j = 0; j < W; j++) begin
        if (j < i && j + K >= i) cc = (x[j] & y[j]) | ((x[j] ^ y[j]) & cc);
      end
      c[i] = cc;
    end
    return c;
  endfunction

  // a full-propagate window whose entering carry could be 1
  function automatic logic window_flag(input logic [W-1:0] x,
                                       input logic [W-1:0] y);
    logic f;
    logic allp;
    f = 1'b0;
    for (int s = 1; s <= W - K; s++) begin
      allp = 1'b1;
      for (int j = 0; j < K; j++) allp = allp & (x[s+j] ^ y[s+j]);
      f = f | (allp & (x[s-1] | y[s-1]));
    end
    return f;
  endfunction

  logic [W:0] pred_c;

  always_comb begin
    pred_c = window_carries(a, b, cin);
    sum    = a ^ b ^ pred_c[W-1:0];
    cout   = pred_c[W];
    err    = window_flag(a, b);
  end

  // R2
  spec_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err |-> ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin})));
endmodule

// File: rtl/spec_prefix_front.sv
module spec_prefix_front #(
  parameter int W   = 32,
  parameter int BLK = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] grp_g,
  output logic [W-1:0] grp_p
);
  localparam int LV   = $clog2(BLK);
  localparam int NBLK = W / BLK;

  // dense prefix levels confined to each block
  always_comb begin
    logic [W-1:0] g, p, gn, pn;
    g = a & b;
    p = a ^ b;
    for (int l = 0; l < LV; l++) begin
      gn = g;
      pn = p;
      for (int i = 0; i < W; i++) begin
        if ((i % BLK) >= (1 << l)) begin
          gn[i] = g[i] | (p[i] & g[i - (1 << l)]);
          pn[i] = p[i] & p[i - (1 << l)];
        end
      end
      g = gn;
      p = pn;
    end
    grp_g = g;
    grp_p = p;
  end

  for (genvar bk = 0; bk < NBLK; bk++) begin : g_blkchk
    logic [BLK:0] slice_sum;
    assign slice_sum = {1'b0, a[bk*BLK +: BLK]} + {1'b0, b[bk*BLK +: BLK]};
    // R4
    blk_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp_g[bk*BLK + BLK - 1] == slice_sum[BLK]);
  end
endmodule

// File: rtl/spec_prefix_back.sv
module spec_prefix_back #(
  parameter int W   = 32,
  parameter int BLK = 8
) (
  input  logic [W-1:0] grp_g,
  input  logic [W-1:0] grp_p,
  input  logic [W-1:0] bit_p,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int NBLK = W / BLK;

  logic [NBLK:0] blk_c;
  logic [W-1:0]  bit_c;

  assign blk_c[0] = cin;

  for (genvar bk = 0; bk < NBLK; bk++) begin : g_blk
    localparam int TOP = bk * BLK + BLK - 1;
    assign blk_c[bk+1] = grp_g[TOP] | (grp_p[TOP] & blk_c[bk]);
    for (genvar j = 0; j < BLK; j++) begin : g_bit
      if (j == 0) begin : g_first
        assign bit_c[bk*BLK] = blk_c[bk];
      end else begin : g_rest
        assign bit_c[bk*BLK + j] = grp_g[bk*BLK + j - 1] |
                                   (grp_p[bk*BLK + j - 1] & blk_c[bk]);
      end
    end
  end

  assign sum  = bit_p ^ bit_c;
  assign cout = blk_c[NBLK];
endmodule

// File: rtl/spec_adder.sv
module spec_adder #(
  parameter int W   = 32,
  parameter int K   = 8,
  parameter int BLK = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_cin,
  output logic         out_done,
  output logic [W-1:0] out_sum,
  output logic         out_cout,
  output logic         stall
);
  import spec_adder_pkg::*;

  phase_t       phase_q;
  logic         accept;
  logic [W-1:0] spec_sum;
  logic         spec_cout;
  logic         spec_err;
  logic [W-1:0] fr_g, fr_p;
  logic [W-1:0] gq, pq, bpq;
  logic         cin_q;
  logic [W-1:0] exact_sum;
  logic         exact_cout;

  assign in_ready = (phase_q == PH_IDLE);
  assign stall    = (phase_q == PH_FINAL);
  assign accept   = in_valid & in_ready;

  spec_fast_path #(.W(W), .K(K)) u_fast (
    .clk(clk), .rst_n(rst_n), .a(in_a), .b(in_b), .cin(in_cin),
    .sum(spec_sum), .cout(spec_cout), .err(spec_err));

  spec_prefix_front #(.W(W), .BLK(BLK)) u_front (
    .clk(clk), .rst_n(rst_n), .a(in_a), .b(in_b),
    .grp_g(fr_g), .grp_p(fr_p));

  spec_prefix_back #(.W(W), .BLK(BLK)) u_back (
    .grp_g(gq), .grp_p(pq), .bit_p(bpq), .cin(cin_q),
    .sum(exact_sum), .cout(exact_cout));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      out_done <= 1'b0;
      out_sum  <= '0;
      out_cout <= 1'b0;
      gq       <= '0;
      pq       <= '0;
      bpq      <= '0;
      cin_q    <= 1'b0;
    end else begin
      out_done <= 1'b0;
      if (phase_q == PH_FINAL) begin
        out_sum  <= exact_sum;
        out_cout <= exact_cout;
        out_done <= 1'b1;
        phase_q  <= PH_IDLE;
      end else if (accept) begin
        gq    <= fr_g;
        pq    <= fr_p;
        bpq   <= in_a ^ in_b;
        cin_q <= in_cin;
        if (spec_err) begin
          phase_q <= PH_FINAL;
        end else begin
          out_sum  <= spec_sum;
          out_cout <= spec_cout;
          out_done <= 1'b1;
        end
      end
    end
  end

  // R2
  fast_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !spec_err) |=> (out_done && !stall));
  // R3
  slow_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && spec_err) |=> (stall && !out_done && !in_ready));
  // R3
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (out_done && !stall));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> ($stable(out_sum) && $stable(out_cout)));
endmodule

// File: tb/spec_adder_test.sv
module spec_adder_test;
  localparam int W = 32;
  localparam int K = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         in_cin = 1'b0;
  logic         out_done;
  logic [W-1:0] out_sum;
  logic         out_cout;
  logic         stall;

  int tests = 0;
  int fails = 0;
  int fast_hits = 0;
  int rand_ops = 0;

  always #4 clk = ~clk;

  spec_adder #(.W(W), .K(K), .BLK(8)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_cin(in_cin), .out_done(out_done),
    .out_sum(out_sum), .out_cout(out_cout), .stall(stall));

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // slow path expected when some start s in 1..W-K has K propagate bits and a|b at s-1
  function automatic bit needs_slow(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] p;
    p = a ^ b;
    for (int s = 1; s <= W - K; s++)
      if ((p[s +: K] == {K{1'b1}}) && (a[s-1] || b[s-1])) return 1'b1;
    return 1'b0;
  endfunction

  // one accepted request; checks latency (R2/R3), value (R4), single strobe (R6)
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic c, input string req);
    logic [W:0] ref_v;
    bit slow;
    ref_v = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    slow = needs_slow(a, b);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_cin = c;
    @(negedge clk);
    in_valid = 1'b0;
    if (!slow) begin
      check({req, " R2 fast done"}, {62'd0, out_done, stall}, 64'b10);
      fast_hits++;
    end else begin
      check({req, " R3 stall"}, {61'd0, stall, in_ready, out_done}, 64'b100);
      @(negedge clk);
      check({req, " R3 second-cycle done"}, {62'd0, out_done, stall}, 64'b10);
    end
    check({req, " R4 sum"}, {31'd0, out_cout, out_sum}, {31'd0, ref_v});
    @(negedge clk);
    check({req, " R6 single strobe"}, {63'd0, out_done}, 64'd0);
    check({req, " R6 held"}, {31'd0, out_cout, out_sum}, {31'd0, ref_v});
  endtask

  task automatic t_reset;
    check("R1 reset flags", {60'd0, out_done, stall, in_ready, out_cout}, 64'b0010);
    check("R1 reset sum", {32'd0, out_sum}, 64'd0);
  endtask

  task automatic t_chain_cases;
    run_op(32'h000000FF, 32'h0, 1'b1, "R7 run from bit0");
    check("R7 value", {31'd0, out_cout, out_sum}, 64'h100);
    run_op(32'h00000FF0, 32'h0, 1'b1, "R8 killed before run");
    run_op(32'h00000FF8, 32'h8, 1'b0, "R8 generate before run");
    check("R8 slow value", {31'd0, out_cout, out_sum}, 64'h1000);
    run_op(32'h000007F8, 32'h8, 1'b0, "R8 short run");
    check("R8 short value", {31'd0, out_cout, out_sum}, 64'h800);
    run_op(32'hFFFFFFFF, 32'h1, 1'b0, "R3 full chain");
    check("R4 carry out", {31'd0, out_cout, out_sum}, 64'h100000000);
    run_op(32'hFFFFFFFF, 32'h0, 1'b1, "R4 cin ripple");
    run_op(32'h80000000, 32'h80000000, 1'b0, "R2 msb gen");
  endtask

  task automatic t_stall_ignore;
    logic [W:0] ref_v;
    ref_v = {1'b0, 32'h00FFFFF0} + {1'b0, 32'h00000010};
    @(negedge clk);
    in_valid = 1'b1; in_a = 32'h00FFFFF0; in_b = 32'h00000010; in_cin = 1'b0;
    @(negedge clk);
    check("R5 stalled", {62'd0, stall, in_ready}, 64'b10);
    in_a = 32'h12345678; in_b = 32'h11111111; in_cin = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 first result", {31'd0, out_cout, out_sum}, {31'd0, ref_v});
    check("R5 done", {63'd0, out_done}, 64'd1);
    @(negedge clk);
    check("R5 no extra done", {63'd0, out_done}, 64'd0);
    check("R5 value kept", {31'd0, out_cout, out_sum}, {31'd0, ref_v});
  endtask

  task automatic t_random;
    for (int n = 0; n < 300; n++) begin
      logic [W-1:0] a, b, m;
      int hits_before;
      a = $urandom;
      m = (n % 3 == 0) ? ($urandom & $urandom & $urandom) : $urandom;
      b = (n % 2 == 0) ? (~a ^ m) : $urandom;
      hits_before = fast_hits;
      run_op(a, b, 1'($urandom % 2), "R4 random");
      rand_ops++;
      if (fast_hits == hits_before) begin end
    end
  endtask

  initial begin
    #2000000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_chain_cases;
    t_stall_ignore;
    fast_hits = 0;
    t_random;
    $display("one-cycle completions: %0d of %0d", fast_hits, rand_ops);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule